// File: doc/BRIEF.md
# Serial Converter Chip-Select Frame Slave

This block is the digital side of a sampling converter that talks over a three-wire serial link. A host pulls chip-select low to take a sample and then clocks out a 16-bit word on the serial data line. The word is four zero bits followed by the 12-bit code, most significant bit first. The analog conversion core is not modelled. Its result arrives on a parallel `sample` input, and the block captures that input at the moment the frame opens.

Chip-select and the serial clock run asynchronously to the block's own system clock. Both are synchronized, and every rising or falling edge is turned into a one-cycle event. A single falling-edge counter then drives all of the frame behaviour:
- it sets which bit is on the line and when the line is released;
- it decides whether an early chip-select release is a plain abort or a power-down request;
- it decides whether a frame started while powered down is long enough to wake the block.

After the wake-up frame, a fixed power-up delay is counted in system clock cycles. The block also reports three things: whether the word of the current frame carries valid data, the cycle in which the acquisition phase begins, and its power state.

Top module: `sconv_slave`

## Requirements
- R1: A chip-select falling edge opens a frame. It captures `sample`, enables the output (`sdo_oe`=1) and drives `sdo`=0. Changing `sample` later in the frame has no effect on the word shifted out.
- R2: Serial clock falling edges 1 to 3 keep `sdo` at 0. Falling edge n, for n from 4 to 15, puts captured bit 15-n on `sdo`, so bit 11 comes first and bit 0 last.
- R3: The 16th serial clock falling edge ends the conversion and releases the line (`sdo_oe`=0). Further falling edges in the same frame change nothing.
- R4: Chip-select rising at any count below 16 aborts the frame and releases the line.
- R5: `acq_start` pulses for one cycle on the first serial clock rising edge after the 13th falling edge. If chip-select rises before that pulse, the next frame reports `data_valid`=0. The one exception is a frame that started a wake-up (R7).
- R6: Chip-select rising in an active frame after 2 to 9 falling edges sets `power_down`=1. Rising after 0, 1 or 10 and more falling edges does not.
- R7: A frame opened while `power_down`=1 reports `data_valid`=0. Its 11th falling edge clears `power_down` and starts the wake-up. If chip-select rises before that edge, the block stays powered down.
- R8: `waking` stays high for WAKE_CYCLES system clocks after the wake-up starts; the default is 100, which is 1 us at 100 MHz. A frame opened while `waking`=1 reports `data_valid`=0.
- R9: Serial clock edges while chip-select is high are ignored. The line stays released and the validity and power state are unchanged.
- R10: After reset the line is released and `power_down`, `waking`, `data_valid` and `acq_start` are 0. The first full frame after reset is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select from the host, active low, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| sample | input | 12 | Parallel conversion result standing in for the analog core |
| sdo | output | 1 | Serial data value, meaningful while sdo_oe is high |
| sdo_oe | output | 1 | Output enable for the tri-state pad; 0 means high impedance |
| data_valid | output | 1 | The word of the current or last frame carries a valid code |
| acq_start | output | 1 | One-cycle pulse when the acquisition phase begins |
| power_down | output | 1 | Block is in power-down |
| waking | output | 1 | Power-up delay is running |

## Verification
The assertions assume that chip-select and serial clock each hold every level for at least three system clocks. This means a synchronized edge event is never lost or merged with the opposite edge. They also assume that a serial clock falling edge never lands in the same system cycle as a chip-select edge. The stimulus holds each serial half-period, and each chip-select level, for six system clocks and changes only one of the two inputs at a time. As a result, every edge event the counter sees is isolated, and the output is sampled well after it has settled.

// File: rtl/sconv_pkg.sv
`timescale 1ns/1ps
package sconv_pkg;

  // Falling-edge counts (after the frame opened) for which a chip-select
  // release is a power-down request: lo <= n < hi.
  function automatic logic pd_window(input logic [7:0] n,
                                     input logic [7:0] lo,
                                     input logic [7:0] hi);
    return (n >= lo) && (n < hi);
  endfunction

  // Index of the captured bit that falling edge n puts on the line.
  function automatic int unsigned code_bit(input int unsigned n,
                                           input int unsigned total);
    return total - 1 - n;
  endfunction

  // True when falling edge n still belongs to the zero preamble.
  function automatic logic in_preamble(input int unsigned n,
                                       input int unsigned lead);
    return n < lead;
  endfunction

endpackage

// File: rtl/sconv_edge_sync.sv
`timescale 1ns/1ps
module sconv_edge_sync #(
  parameter int          WIDTH   = 2,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] IDLE = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [STAGES:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= {(STAGES+1){IDLE[i]}};
        else        sh <= {sh[STAGES-1:0], din[i]};
      end
      assign rise[i] =  sh[STAGES-1] & ~sh[STAGES];
      assign fall[i] = ~sh[STAGES-1] &  sh[STAGES];
    end
  endgenerate
endmodule

// File: rtl/sconv_frame_seq.sv
`timescale 1ns/1ps
module sconv_frame_seq
  import sconv_pkg::*;
#(
  parameter int FRAME_FALLS = 16,
  parameter int PD_LO       = 2,
  parameter int PD_HI       = 10,
  parameter int WAKE_FALLS  = 11,
  parameter int ACQ_FALL    = 13,
  parameter int WAKE_CYCLES = 100,
  localparam int CNT_W      = $clog2(FRAME_FALLS + 1),
  localparam int WK_W       = $clog2(WAKE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             sclk_fall,
  input  logic             sclk_rise,
  output logic             in_frame,
  output logic [CNT_W-1:0] cnt,
  output logic             fall_take,
  output logic             data_valid,
  output logic             acq_start,
  output logic             power_down,
  output logic             waking
);
  localparam logic [CNT_W-1:0] LAST_N = CNT_W'(FRAME_FALLS);
  localparam logic [CNT_W-1:0] WAKE_N = CNT_W'(WAKE_FALLS);
  localparam logic [CNT_W-1:0] ACQ_N  = CNT_W'(ACQ_FALL);
  localparam logic [WK_W-1:0]  WAKE_T = WK_W'(WAKE_CYCLES);

  logic             acq_seen, acq_ok, pd_start;
  logic [WK_W-1:0]  wake_cnt;
  logic [CNT_W-1:0] cnt_nx;
  logic             woke_now, pd_req;

  assign fall_take = sclk_fall && in_frame && (cnt < LAST_N);
  assign cnt_nx    = cnt + 1'b1;
  assign woke_now  = pd_start && (cnt >= WAKE_N);
  assign pd_req    = pd_window(8'(cnt), 8'(PD_LO), 8'(PD_HI));
  assign waking    = (wake_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame   <= 1'b0;
      cnt        <= '0;
      acq_seen   <= 1'b0;
      acq_ok     <= 1'b1;
      pd_start   <= 1'b0;
      power_down <= 1'b0;
      wake_cnt   <= '0;
      data_valid <= 1'b0;
      acq_start  <= 1'b0;
    end else begin
      acq_start <= 1'b0;
      if (waking) wake_cnt <= wake_cnt - 1'b1;
      if (cs_fall) begin
        in_frame   <= 1'b1;
        cnt        <= '0;
        acq_seen   <= 1'b0;
        pd_start   <= power_down;
        data_valid <= !power_down && !waking && acq_ok;
      end else if (cs_rise && in_frame) begin
        in_frame <= 1'b0;
        if (!acq_seen && !woke_now) acq_ok <= 1'b0;
        if (!pd_start && pd_req) power_down <= 1'b1;
      end else if (in_frame) begin
        if (fall_take) begin
          cnt <= cnt_nx;
          if (pd_start && cnt_nx == WAKE_N) begin
            power_down <= 1'b0;
            wake_cnt   <= WAKE_T;
            acq_ok     <= 1'b1;
          end
        end
        if (sclk_rise && cnt >= ACQ_N && !acq_seen) begin
          acq_seen  <= 1'b1;
          acq_start <= 1'b1;
          acq_ok    <= 1'b1;
        end
      end
    end
  end

  assert_acq_after_13_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acq_start |-> ($past(sclk_rise) && $past(cnt) >= ACQ_N));
  assert_pd_from_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_down) |-> $past(cs_rise));
  assert_wake_from_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(waking) |-> ($past(sclk_fall) && $past(pd_start)));
  assert_valid_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && $past(in_frame)) |-> $stable(data_valid));
  assert_no_valid_waking_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(in_frame) && $past(waking)) |-> !data_valid);
endmodule

// File: rtl/sconv_sdo_drv.sv
`timescale 1ns/1ps
module sconv_sdo_drv
  import sconv_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int LEAD_ZEROS = 4,
  localparam int TOTAL     = LEAD_ZEROS + DATA_W,
  localparam int CNT_W     = $clog2(TOTAL + 1),
  localparam int IDX_W     = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] sample,
  input  logic              start,
  input  logic              stop,
  input  logic              fall_take,
  input  logic [CNT_W-1:0]  cnt,
  output logic              sdo,
  output logic              sdo_oe
);
  logic [DATA_W-1:0] hold;
  logic [CNT_W-1:0]  n;
  logic [IDX_W-1:0]  idx;

  assign n   = cnt + 1'b1;
  assign idx = IDX_W'(code_bit(int'(n), TOTAL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold   <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (start) begin
      hold   <= sample;
      sdo    <= 1'b0;
      sdo_oe <= 1'b1;
    end else if (stop) begin
      sdo_oe <= 1'b0;
    end else if (fall_take) begin
      if (n >= CNT_W'(TOTAL))                  sdo_oe <= 1'b0;
      else if (in_preamble(int'(n), LEAD_ZEROS)) sdo <= 1'b0;
      else                                     sdo <= hold[idx];
    end
  end
endmodule

// File: rtl/sconv_slave.sv
`timescale 1ns/1ps
module sconv_slave #(
  parameter int DATA_W      = 12,
  parameter int LEAD_ZEROS  = 4,
  parameter int PD_LO       = 2,
  parameter int PD_HI       = 10,
  parameter int WAKE_FALLS  = 11,
  parameter int WAKE_CYCLES = 100,
  parameter int SYNC_STAGES = 2,
  localparam int FRAME_FALLS = LEAD_ZEROS + DATA_W,
  localparam int ACQ_FALL    = FRAME_FALLS - 3,
  localparam int CNT_W       = $clog2(FRAME_FALLS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] sample,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              data_valid,
  output logic              acq_start,
  output logic              power_down,
  output logic              waking
);
  logic [1:0]       rise_v, fall_v;
  logic             cs_fall, cs_rise, sclk_fall, sclk_rise;
  logic             in_frame, fall_take;
  logic [CNT_W-1:0] cnt;

  sconv_edge_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .IDLE(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({sclk, cs_n}), .rise(rise_v), .fall(fall_v));

  // cs_n is active low: its falling edge opens a frame.
  assign cs_fall   = fall_v[0];
  assign cs_rise   = rise_v[0];
  assign sclk_fall = fall_v[1];
  assign sclk_rise = rise_v[1];

  sconv_frame_seq #(
    .FRAME_FALLS(FRAME_FALLS), .PD_LO(PD_LO), .PD_HI(PD_HI),
    .WAKE_FALLS(WAKE_FALLS), .ACQ_FALL(ACQ_FALL), .WAKE_CYCLES(WAKE_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_fall(sclk_fall), .sclk_rise(sclk_rise), .in_frame(in_frame),
    .cnt(cnt), .fall_take(fall_take), .data_valid(data_valid),
    .acq_start(acq_start), .power_down(power_down), .waking(waking));

  sconv_sdo_drv #(.DATA_W(DATA_W), .LEAD_ZEROS(LEAD_ZEROS)) u_drv (
    .clk(clk), .rst_n(rst_n), .sample(sample), .start(cs_fall),
    .stop(cs_rise), .fall_take(fall_take), .cnt(cnt),
    .sdo(sdo), .sdo_oe(sdo_oe));

  assert_oe_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> in_frame);
  assert_release_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdo_oe) |-> ($past(cs_rise) ||
                       ($past(fall_take) && $past(cnt) == CNT_W'(FRAME_FALLS - 1))));
  assert_idle_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_frame && !cs_fall) |=> !sdo_oe);
endmodule

// File: tb/tb_sconv_slave.sv
`timescale 1ns/1ps
module tb_sconv_slave;
  localparam int H = 6;

  typedef struct packed {
    logic [11:0] smp;
    logic [4:0]  nf;
    logic        lr;
    logic [7:0]  gap;
    logic        v;
    logic        pd;
    logic        wk;
  } vec_t;

  // smp, falls, rise after last fall, gap, expected valid / power_down / waking
  localparam vec_t VEC [17] = '{
    '{12'hA5C, 5'd16, 1'b1, 8'd8,   1'b1, 1'b0, 1'b0},
    '{12'h3F1, 5'd16, 1'b1, 8'd8,   1'b1, 1'b0, 1'b0},
    '{12'h123, 5'd13, 1'b0, 8'd8,   1'b1, 1'b0, 1'b0},
    '{12'h456, 5'd16, 1'b1, 8'd8,   1'b0, 1'b0, 1'b0},
    '{12'h789, 5'd16, 1'b1, 8'd8,   1'b1, 1'b0, 1'b0},
    '{12'h0FF, 5'd2,  1'b1, 8'd8,   1'b1, 1'b1, 1'b0},
    '{12'h5A5, 5'd10, 1'b1, 8'd8,   1'b0, 1'b1, 1'b0},
    '{12'hFFF, 5'd11, 1'b1, 8'd200, 1'b0, 1'b0, 1'b1},
    '{12'hABC, 5'd16, 1'b1, 8'd8,   1'b1, 1'b0, 1'b0},
    '{12'h111, 5'd9,  1'b1, 8'd8,   1'b1, 1'b1, 1'b0},
    '{12'h222, 5'd12, 1'b1, 8'd8,   1'b0, 1'b0, 1'b1},
    '{12'h333, 5'd16, 1'b1, 8'd8,   1'b0, 1'b0, 1'b0},
    '{12'h444, 5'd10, 1'b1, 8'd8,   1'b1, 1'b0, 1'b0},
    '{12'h555, 5'd16, 1'b1, 8'd8,   1'b0, 1'b0, 1'b0},
    '{12'h000, 5'd1,  1'b1, 8'd8,   1'b1, 1'b0, 1'b0},
    '{12'h666, 5'd16, 1'b1, 8'd8,   1'b0, 1'b0, 1'b0},
    '{12'h800, 5'd16, 1'b1, 8'd8,   1'b1, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b1;
  logic [11:0] sample = '0;
  logic sdo, sdo_oe, data_valid, acq_start, power_down, waking;
  int n_run = 0, n_fail = 0, acq_cnt = 0;

  always #5 clk = ~clk;

  sconv_slave dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .sample(sample), .sdo(sdo), .sdo_oe(sdo_oe), .data_valid(data_valid),
    .acq_start(acq_start), .power_down(power_down), .waking(waking));

  always @(negedge clk) if (acq_start) acq_cnt++;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input vec_t f);
    logic [11:0] word = '0;
    logic pre_ok = 1'b1, oe16 = 1'b1;
    int a0;
    sample = f.smp;
    cs_n = 1'b0;
    wcyc(H);
    chk(sdo_oe === 1'b1 && sdo === 1'b0, "R1 open", {sdo_oe, sdo}, 2);
    chk(data_valid === f.v, "R5/R7/R8 valid", data_valid, f.v);
    sample = ~f.smp;  // R1: late change must not leak into the word
    a0 = acq_cnt;
    for (int k = 1; k <= int'(f.nf); k++) begin
      sclk = 1'b0;
      wcyc(H);
      if (k <= 3 && !(sdo === 1'b0 && sdo_oe === 1'b1)) pre_ok = 1'b0;
      if (k >= 4 && k <= 15) word[15-k] = sdo;
      if (k == 16) oe16 = sdo_oe;
      if (k < int'(f.nf) || f.lr) begin
        sclk = 1'b1;
        wcyc(H);
      end
    end
    if (f.nf == 5'd16) begin
      chk(pre_ok, "R2 preamble", pre_ok, 1);
      chk(word === f.smp, "R2 word", word, f.smp);
      chk(oe16 === 1'b0, "R3 release at 16", oe16, 0);
    end
    chk((acq_cnt - a0) == ((f.nf >= 5'd14 || (f.nf == 5'd13 && f.lr)) ? 1 : 0),
        "R5 acq pulse", acq_cnt - a0, (f.nf >= 5'd14 || (f.nf == 5'd13 && f.lr)) ? 1 : 0);
    cs_n = 1'b1;
    wcyc(H);
    chk(sdo_oe === 1'b0, "R4 released", sdo_oe, 0);
    chk(power_down === f.pd, "R6/R7 power_down", power_down, f.pd);
    chk(waking === f.wk, "R8 waking", waking, f.wk);
    sclk = 1'b1;
    wcyc(int'(f.gap));
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wcyc(4);
    rst_n = 1'b1;
    wcyc(H);
    // R10 reset state
    chk(sdo_oe === 1'b0 && power_down === 1'b0 && waking === 1'b0 &&
        data_valid === 1'b0 && acq_cnt == 0, "R10 reset state",
        {sdo_oe, power_down, waking, data_valid}, 0);

    for (int i = 0; i < 17; i++) frame(VEC[i]);

    // R9: serial clock toggles with chip-select high
    for (int i = 0; i < 20; i++) begin
      sclk = ~sclk;
      wcyc(H);
    end
    sclk = 1'b1;
    wcyc(H);
    chk(sdo_oe === 1'b0 && power_down === 1'b0, "R9 idle clocks", {sdo_oe, power_down}, 0);
    frame('{12'h9C3, 5'd16, 1'b1, 8'd8, 1'b1, 1'b0, 1'b0});

    // R10: reset in the middle of a frame
    cs_n = 1'b0;
    wcyc(H);
    for (int k = 0; k < 5; k++) begin
      sclk = 1'b0; wcyc(H); sclk = 1'b1; wcyc(H);
    end
    rst_n = 1'b0;
    wcyc(2);
    chk(sdo_oe === 1'b0 && power_down === 1'b0, "R10 reset mid-frame", {sdo_oe, power_down}, 0);
    cs_n = 1'b1;
    wcyc(H);
    rst_n = 1'b1;
    wcyc(H);
    chk(power_down === 1'b0 && sdo_oe === 1'b0, "R10 after release", {power_down, sdo_oe}, 0);
    frame('{12'h7E1, 5'd16, 1'b1, 8'd8, 1'b1, 1'b0, 1'b0});

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule